// File: doc/BRIEF.md
# Disc Motor PWM Speed Controller

This block drives a disc spindle motor through a single pulse-width-modulated line. A free-running 128-step timebase, clocked by the 11.2896 MHz system clock, gives a pulse rate near 88 kHz. In normal running, the fraction of each period during which the line is pulled low is set by a speed-error code from an external rate-control loop. That code is clamped to the legal range of 1/64 through 63/64.

A start/stop request line is read once at the start of every high phase of the subcode word clock. A change in its level is treated as an event. A rise to high starts the motor: the drive is pinned at 63/64 for a fixed number of PWM periods (17640 by default, about 0.2 s) and then follows the speed code. A fall to low stops the motor: the drive is pinned at 1/64 for the same number of periods and then settles at a steady 50% until the next start. After reset the block sits in that steady 50% state.

The output is meant for an open-drain pad. When `pwm_pull` is high the pad is driven low. When `pwm_pull` is low the pad is released.

Top module: `disc_motor_pwm`

## Requirements
- R1: The PWM period is exactly 128 clocks. Within a period whose loaded duty is D, `pwm_pull` is 1 for the first 2*D clocks and 0 for the remaining clocks.
- R2: In the running state, D is `speed_code` clamped to 1..63. A code of 0 gives 1, and any code of 64 or above gives 63.
- R3: D is loaded only on the last clock of a period. A change to `speed_code` or to the operating state in the middle of a period does not alter that period's pulse.
- R4: `ss_line` is sampled only on a clock where `word_clk` is 1 and was 0 on the previous clock. Changes of `ss_line` at any other time have no effect. A sample equal to the previous sample is not an event.
- R5: A sample of 1 that follows a sample of 0 is a start event. Each of the next OVR_PERIODS periods gets D = 63. After that, the running state (R2) follows.
- R6: A sample of 0 that follows a sample of 1 is a stop event. Each of the next OVR_PERIODS periods gets D = 1. After that, D = 32 for every period until a start event.
- R7: Reset is synchronous and active high. After reset, the period counter is at 0, D = 32, the controller is in the steady 50% state, and the last sample is taken as 0.
- R8: A start event during a stop override cancels the stop override and begins a full start override of OVR_PERIODS periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (11.2896 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| speed_code | input | 7 | Speed-error code from the rate loop; clamped to 1..63 |
| word_clk | input | 1 | Subcode word clock; its rising edge samples `ss_line` |
| ss_line | input | 1 | Start/stop request: 1 = run, 0 = stop |
| pwm_pull | output | 1 | 1 = drive the open-drain pad low, 0 = release it |

## Verification
The bench targets five corner cases:
- **Clamping.** Codes 0, 1, 63, 64 and 100 are applied. A design that passed the raw code through would give a flat output for code 0, or wrap code 64 and above to a tiny duty.
- **Mid-period code change.** The speed code is changed part-way through a period. A design that loaded it at once would cut the pulse short.
- **Noise on the request line.** `ss_line` is toggled while `word_clk` is low, and again inside a high phase. An edge detector placed on the wrong signal would create stop events that were never requested.
- **Override timing.** The number of override periods is counted. A design with an off-by-one in the terminal count would fail here.
- **Start during a stop override.** A sequencer that ignored the start event, or resumed the stop timing, would leave the motor braking.

// File: rtl/disc_motor_pkg.sv
package disc_motor_pkg;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'd0,
        MD_START = 2'd1,
        MD_RUN   = 2'd2,
        MD_STOP  = 2'd3
    } motor_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
    } ss_evt_t;

    function automatic logic is_override(input motor_mode_e m);
        return (m == MD_START) || (m == MD_STOP);
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign wrap = &cnt;
endmodule

// File: rtl/ss_sense.sv
module ss_sense
    import disc_motor_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    word_clk,
    input  logic    ss_line,
    output ss_evt_t evt
);
    logic wc_q;
    logic line_q;
    logic sample;

    assign sample = word_clk & ~wc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wc_q   <= 1'b0;
            line_q <= 1'b0;
        end else begin
            wc_q <= word_clk;
            if (sample) line_q <= ss_line;
        end
    end

    always_comb begin
        evt.start = sample &  ss_line & ~line_q;
        evt.stop  = sample & ~ss_line &  line_q;
    end
endmodule

// File: rtl/ovr_seq.sv
module ovr_seq
    import disc_motor_pkg::*;
#(
    parameter int OVR_PERIODS = 17640
) (
    input  logic        clk,
    input  logic        rst,
    input  ss_evt_t     evt,
    input  logic        wrap,
    output motor_mode_e mode
);
    localparam int OVR_W = (OVR_PERIODS > 1) ? $clog2(OVR_PERIODS) : 1;
    localparam logic [OVR_W-1:0] LAST = OVR_W'(OVR_PERIODS - 1);

    logic [OVR_W-1:0] ovr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MD_IDLE;
            ovr_cnt <= '0;
        end else if (evt.start) begin
            mode    <= MD_START;
            ovr_cnt <= '0;
        end else if (evt.stop) begin
            mode    <= MD_STOP;
            ovr_cnt <= '0;
        end else if (wrap && is_override(mode)) begin
            if (ovr_cnt == LAST) begin
                mode    <= (mode == MD_START) ? MD_RUN : MD_IDLE;
                ovr_cnt <= '0;
            end else begin
                ovr_cnt <= ovr_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_drive.sv
module pwm_drive
    import disc_motor_pkg::*;
#(
    parameter int DUTY_W = 6,
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  motor_mode_e       mode,
    input  logic              wrap,
    input  logic [DUTY_W:0]   cnt,
    input  logic [CODE_W-1:0] speed_code,
    output logic [DUTY_W-1:0] duty_q,
    output logic              pwm_pull
);
    localparam int                MAX_I  = (1 << DUTY_W) - 1;
    localparam logic [DUTY_W-1:0] D_MAX  = DUTY_W'(MAX_I);
    localparam logic [DUTY_W-1:0] D_MIN  = DUTY_W'(1);
    localparam logic [DUTY_W-1:0] D_HALF = DUTY_W'(1 << (DUTY_W - 1));
    localparam logic [CODE_W-1:0] C_MAX  = CODE_W'(MAX_I);

    logic [DUTY_W-1:0] run_duty;
    logic [DUTY_W-1:0] next_duty;

    always_comb begin
        if (speed_code == '0)        run_duty = D_MIN;
        else if (speed_code > C_MAX) run_duty = D_MAX;
        else                         run_duty = speed_code[DUTY_W-1:0];
    end

    always_comb begin
        unique case (mode)
            MD_START: next_duty = D_MAX;
            MD_STOP:  next_duty = D_MIN;
            MD_RUN:   next_duty = run_duty;
            default:  next_duty = D_HALF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       duty_q <= D_HALF;
        else if (wrap) duty_q <= next_duty;
    end

    assign pwm_pull = (cnt < {duty_q, 1'b0});
endmodule

// File: rtl/disc_motor_pwm.sv
module disc_motor_pwm
    import disc_motor_pkg::*;
#(
    parameter int DUTY_W      = 6,
    parameter int CODE_W      = 7,
    parameter int OVR_PERIODS = 17640
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] speed_code,
    input  logic              word_clk,
    input  logic              ss_line,
    output logic              pwm_pull
);
    localparam int CNT_W = DUTY_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    ss_evt_t           evt;
    motor_mode_e       mode;
    logic [DUTY_W-1:0] duty_q;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt),
        .wrap (wrap)
    );

    ss_sense u_ss (
        .clk      (clk),
        .rst      (rst),
        .word_clk (word_clk),
        .ss_line  (ss_line),
        .evt      (evt)
    );

    ovr_seq #(.OVR_PERIODS(OVR_PERIODS)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .wrap (wrap),
        .mode (mode)
    );

    pwm_drive #(.DUTY_W(DUTY_W), .CODE_W(CODE_W)) u_drv (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .wrap       (wrap),
        .cnt        (cnt),
        .speed_code (speed_code),
        .duty_q     (duty_q),
        .pwm_pull   (pwm_pull)
    );
endmodule

// File: rtl/disc_motor_pwm_chk.sv
module disc_motor_pwm_chk
    import disc_motor_pkg::*;
#(
    parameter int DUTY_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [DUTY_W:0]   cnt,
    input logic [DUTY_W-1:0] duty,
    input motor_mode_e       mode
);
    localparam logic [DUTY_W:0]   CNT_TOP = {(DUTY_W+1){1'b1}};
    localparam logic [DUTY_W-1:0] D_MAX   = {DUTY_W{1'b1}};
    localparam logic [DUTY_W-1:0] D_MIN   = DUTY_W'(1);
    localparam logic [DUTY_W-1:0] D_HALF  = DUTY_W'(1 << (DUTY_W - 1));

    // R1
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_TOP) |=> (cnt == '0));

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $stable(duty));

    // R2
    duty_range_chk: assert property (@(posedge clk) disable iff (rst)
        (duty != '0));

    // R5
    start_force_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && $past(mode == MD_START)) |-> (duty == D_MAX));

    // R6
    stop_force_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && $past(mode == MD_STOP)) |-> (duty == D_MIN));

    // R6
    idle_half_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt == '0) && $past(mode == MD_IDLE)) |-> (duty == D_HALF));

    // R8
    stop_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode == MD_STOP) && (mode != MD_STOP)) |-> (mode == MD_IDLE || mode == MD_START));

    // R5
    start_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode == MD_START) && (mode != MD_START)) |-> (mode == MD_RUN || mode == MD_STOP));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && duty == D_HALF && mode == MD_IDLE));
endmodule

bind disc_motor_pwm disc_motor_pwm_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .cnt  (cnt),
    .duty (duty_q),
    .mode (mode)
);

// File: tb/disc_motor_pwm_test.sv
module disc_motor_pwm_test;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] speed_code = 7'd0;
    logic       word_clk = 1'b0;
    logic       ss_line = 1'b0;
    logic       pwm_pull;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // behavioural reference model state
    int m_pos, m_duty, m_mode, m_ovr, m_line, m_wcprev;

    disc_motor_pwm #(.DUTY_W(6), .CODE_W(7), .OVR_PERIODS(N)) uut (
        .clk(clk), .rst(rst), .speed_code(speed_code),
        .word_clk(word_clk), .ss_line(ss_line), .pwm_pull(pwm_pull)
    );

    always #5 clk = ~clk;

    function automatic int clamp(input int c);
        if (c < 1) return 1;
        if (c > 63) return 63;
        return c;
    endfunction

    // mode: 0 idle, 1 start, 2 run, 3 stop
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_pos = 0; m_duty = 32; m_mode = 0; m_ovr = 0; m_line = 0; m_wcprev = 0;
        end else begin
            bit smp, st, sp;
            int nd;
            smp = word_clk && (m_wcprev == 0);
            st  = smp && ss_line && (m_line == 0);
            sp  = smp && !ss_line && (m_line == 1);
            case (m_mode)
                1: nd = 63;
                3: nd = 1;
                2: nd = clamp(int'(speed_code));
                default: nd = 32;
            endcase
            if (m_pos == 127) m_duty = nd;
            if (st) begin m_mode = 1; m_ovr = 0; end
            else if (sp) begin m_mode = 3; m_ovr = 0; end
            else if (m_pos == 127 && (m_mode == 1 || m_mode == 3)) begin
                if (m_ovr == N - 1) begin m_mode = (m_mode == 1) ? 2 : 0; m_ovr = 0; end
                else m_ovr++;
            end
            m_pos = (m_pos + 1) % 128;
            m_wcprev = word_clk ? 1 : 0;
            if (smp) m_line = ss_line ? 1 : 0;
        end
    end

    // per-clock comparison of the pulse shape against the model
    always @(negedge clk) begin
        if (!rst && cyc > 1) begin
            bit exp;
            exp = (m_pos < 2 * m_duty);
            checks++;
            if (pwm_pull !== exp) begin
                errors++;
                $display("FAIL R1 cycle %0d pos %0d: pwm_pull=%b expected=%b", cyc, m_pos, pwm_pull, exp);
            end
        end
    end

    task automatic measure(input int exp_high, input string tag,
                           input int chg_at = -1, input int chg_val = 0);
        int high = 0;
        @(negedge clk);
        while (m_pos != 0) @(negedge clk);
        for (int i = 0; i < 128; i++) begin
            if (i == chg_at) speed_code = 7'(chg_val);
            if (pwm_pull) high++;
            if (i != 127) @(negedge clk);
        end
        checks++;
        if (high != exp_high) begin
            errors++;
            $display("FAIL %s high clocks actual=%0d expected=%0d", tag, high, exp_high);
        end
    endtask

    task automatic wc_sample(input bit lvl);
        @(negedge clk);
        ss_line = lvl; word_clk = 1'b1;
        @(negedge clk);
        ss_line = ~lvl;          // noise inside the high phase: ignored (R4)
        @(negedge clk);
        @(negedge clk);
        word_clk = 1'b0; ss_line = lvl;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: reset state is steady 50%
        measure(64, "R7");
        speed_code = 7'd20;
        measure(64, "R7");

        // R5: start override then running
        wc_sample(1'b1);
        for (int k = 0; k < N; k++) measure(126, "R5");
        measure(40, "R5");

        // R2: clamping
        speed_code = 7'd0;   measure(2, "R2");
        speed_code = 7'd100; measure(126, "R2");
        speed_code = 7'd64;  measure(126, "R2");
        speed_code = 7'd63;  measure(126, "R2");
        speed_code = 7'd1;   measure(2, "R2");
        speed_code = 7'd33;  measure(66, "R2");

        // R3: mid-period change does not affect current period
        speed_code = 7'd50;  measure(100, "R3");
        measure(100, "R3", 30, 10);
        measure(20, "R3");

        // R4: line changes with word clock low, and repeated equal samples
        @(negedge clk); ss_line = 1'b0;
        repeat (40) @(negedge clk);
        ss_line = 1'b1;
        measure(20, "R4");
        wc_sample(1'b1);
        measure(20, "R4");

        // R6: stop override then steady half
        wc_sample(1'b0);
        for (int k = 0; k < N; k++) measure(2, "R6");
        measure(64, "R6");
        speed_code = 7'd5;
        measure(64, "R6");

        // R8: start during stop override
        wc_sample(1'b1);
        measure(126, "R8");
        wc_sample(1'b0);
        measure(2, "R8");
        wc_sample(1'b1);
        for (int k = 0; k < N; k++) measure(126, "R8");
        measure(10, "R8");

        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 100000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule